// File: doc/BRIEF.md
# Binary64 Compare Flag Generator

This block compares two packed IEEE-754 double-precision words and reports the outcome as a four-bit condition code (negative, zero, carry, overflow), together with a flag for an invalid operation. A select input replaces the second operand with positive zero, which gives a compare-against-zero. A second select makes quiet NaNs raise the invalid flag as well as signalling ones.

The ordering works on the raw words. Each operand is classified for NaN. Two zeros of either sign count as equal. Operands with opposite signs are ordered by the sign of the first operand. Operands with the same sign are ordered by an unsigned integer compare of the words, and that result is inverted when both are negative. There is no unpacking, normalisation or subtraction. The outputs are registered, one cycle after the strobe. The block feeds a status register kept elsewhere.

Top module: `fcmp_flag_gen`

## Requirements
- R1: While reset is held (rst_n low at a clock edge), `nzcv` and `invalid` become zero.
- R2: A cycle with `in_valid` low gives `nzcv` = 0000 and `invalid` = 0 after the next edge, whatever the operands are.
- R3: When D equals M, `nzcv` = 0110 (bit 3 is N, bit 2 is Z, bit 1 is C, bit 0 is V). +0 and -0 count as equal, and so do equal subnormals.
- R4: When D is less than M, `nzcv` = 1000. This includes opposite signs, adjacent values and infinities.
- R5: When D is greater than M, `nzcv` = 0010.
- R6: An operand is a NaN when its exponent field (bits 62:52) is all ones and its fraction field (bits 51:0) is nonzero. If either operand is a NaN, `nzcv` = 0011 (unordered).
- R7: A NaN whose fraction bit 51 is clear is signalling and always sets `invalid`. A compare with no NaN operand leaves `invalid` at 0.
- R8: A quiet NaN (fraction bit 51 set) sets `invalid` only when `sig_qnan` is 1.
- R9: When `cmp_zero` is 1, the value on `opd_m` has no effect and D is compared with +0.
- R10: The results for the operands presented at one clock edge appear on the outputs just after that edge and stay there until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: a compare is requested in this cycle |
| opd_d | input | 64 | First operand, packed binary64 |
| opd_m | input | 64 | Second operand, packed binary64 |
| cmp_zero | input | 1 | Compare D with +0 instead of M |
| sig_qnan | input | 1 | Quiet NaNs also raise invalid |
| nzcv | output | 4 | Condition code, N at bit 3 down to V at bit 0 |
| invalid | output | 1 | Invalid-operation flag |

## Verification
Both outputs are due exactly one rising edge after the strobe and operands are driven. The bench drives inputs on a falling edge and samples on the following falling edge, so a single register lies between stimulus and check. The sweep applies every pair from a set of special values (signed zeros, subnormals, adjacent normals, extreme finites, infinities and NaNs) under all four settings of the two selects. The expected code is computed with real-number comparison plus a NaN classification taken from the requirements. Idle cycles are checked in the same way, one edge after the strobe drops.

// File: rtl/fcmp_pkg.sv
// Package: shared types and condition-code encodings for the binary64
// compare block. Assumes NZCV order N=bit3, Z=bit2, C=bit1, V=bit0.
package fcmp_pkg;

    // Per-operand classification result.
    typedef struct packed {
        logic is_nan;    // exponent all ones, fraction nonzero
        logic is_quiet;  // top fraction bit set
    } opnd_class_t;

    localparam logic [3:0] CC_NONE  = 4'b0000;
    localparam logic [3:0] CC_EQUAL = 4'b0110;
    localparam logic [3:0] CC_LESS  = 4'b1000;
    localparam logic [3:0] CC_GREAT = 4'b0010;
    localparam logic [3:0] CC_UNORD = 4'b0011;

endpackage

// File: rtl/fcmp_classify.sv
// Module: fcmp_classify
// Detects whether one packed floating-point word is a NaN and whether
// that NaN is quiet. Assumes layout sign | exponent | fraction with the
// quiet bit as the most significant fraction bit.
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0]  word,
    output opnd_class_t   cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    // Split the word and classify it.
    always_comb begin
        exp_f        = word[W-2 -: EXP_W];
        frac_f       = word[FRAC_W-1:0];
        cls.is_nan   = (&exp_f) && (|frac_f);
        cls.is_quiet = frac_f[FRAC_W-1];
    end
endmodule

// File: rtl/fcmp_order.sv
// Module: fcmp_order
// Orders two packed sign-magnitude words using integer logic only.
// Assumes neither word is a NaN (the caller masks NaN cases). Exactly one
// of eq/lt/gt is high for any pair of non-NaN inputs.
module fcmp_order #(
    parameter int W = 64
) (
    input  logic [W-1:0] d,
    input  logic [W-1:0] m,
    output logic         eq,
    output logic         lt,
    output logic         gt
);
    logic         sd;
    logic         sm;
    logic [W-1:0] mag_or;
    logic         u_lt;
    logic         u_gt;

    // Decide equality, then sign-based or magnitude-based ordering.
    always_comb begin
        sd     = d[W-1];
        sm     = m[W-1];
        mag_or = (d | m) & {1'b0, {(W-1){1'b1}}};
        u_lt   = d < m;
        u_gt   = d > m;
        eq     = (d == m) || (mag_or == '0);
        lt     = 1'b0;
        gt     = 1'b0;
        if (!eq) begin
            if (sd != sm) begin
                lt = sd;
                gt = !sd;
            end else begin
                lt = sd ^ u_lt;
                gt = sd ^ u_gt;
            end
        end
    end
endmodule

// File: rtl/fcmp_flag_gen.sv
// Module: fcmp_flag_gen (top)
// Compares two packed floating-point words (or D against +0) and
// registers an NZCV condition code and an invalid-operation flag one cycle
// after the strobe. Assumes synchronous active-low reset; flags are zero
// for idle cycles.
module fcmp_flag_gen
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] opd_d,
    input  logic [W-1:0] opd_m,
    input  logic         cmp_zero,
    input  logic         sig_qnan,
    output logic [3:0]   nzcv,
    output logic         invalid
);
    logic [W-1:0] m_eff;
    opnd_class_t  cls_d;
    opnd_class_t  cls_m;
    logic         ord_eq;
    logic         ord_lt;
    logic         ord_gt;
    logic         any_nan;
    logic         raise_d;
    logic         raise_m;
    logic [3:0]   cc_next;
    logic         inv_next;

    // Substitute +0 for the second operand in compare-with-zero mode.
    always_comb m_eff = cmp_zero ? '0 : opd_m;

    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_d (
        .word (opd_d),
        .cls  (cls_d)
    );

    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_m (
        .word (m_eff),
        .cls  (cls_m)
    );

    fcmp_order #(.W(W)) u_order (
        .d  (opd_d),
        .m  (m_eff),
        .eq (ord_eq),
        .lt (ord_lt),
        .gt (ord_gt)
    );

    // Merge NaN handling with the ordering into next-state flags.
    always_comb begin
        any_nan  = cls_d.is_nan || cls_m.is_nan;
        raise_d  = cls_d.is_nan && (!cls_d.is_quiet || sig_qnan);
        raise_m  = cls_m.is_nan && (!cls_m.is_quiet || sig_qnan);
        cc_next  = CC_NONE;
        inv_next = 1'b0;
        if (in_valid) begin
            inv_next = raise_d || raise_m;
            if (any_nan)     cc_next = CC_UNORD;
            else if (ord_eq) cc_next = CC_EQUAL;
            else if (ord_lt) cc_next = CC_LESS;
            else if (ord_gt) cc_next = CC_GREAT;
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nzcv    <= CC_NONE;
            invalid <= 1'b0;
        end else begin
            nzcv    <= cc_next;
            invalid <= inv_next;
        end
    end

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (nzcv == CC_NONE && !invalid)); // R2

    AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_nan) |=> (nzcv == CC_UNORD)); // R6

    AST_SNAN_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((cls_d.is_nan && !cls_d.is_quiet) ||
                      (cls_m.is_nan && !cls_m.is_quiet))) |=> invalid); // R7

    AST_NO_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any_nan) |=> !invalid); // R7

    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any_nan) |-> $countones({ord_eq, ord_lt, ord_gt}) == 1); // R3

    AST_ZERO_MODE_OPND: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_zero |-> !cls_m.is_nan); // R9
endmodule

// File: tb/fcmp_flag_gen_bench.sv
module fcmp_flag_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] opd_d = '0;
    logic [63:0] opd_m = '0;
    logic        cmp_zero = 1'b0;
    logic        sig_qnan = 1'b0;
    logic [3:0]  nzcv;
    logic        invalid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    fcmp_flag_gen u_fcmp_flag_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .opd_d    (opd_d),
        .opd_m    (opd_m),
        .cmp_zero (cmp_zero),
        .sig_qnan (sig_qnan),
        .nzcv     (nzcv),
        .invalid  (invalid)
    );

    localparam int NV = 18;

    function automatic logic [63:0] pick(input int i);
        case (i)
            0:  return 64'h0000_0000_0000_0000; // +0
            1:  return 64'h8000_0000_0000_0000; // -0
            2:  return 64'h0000_0000_0000_0001; // min subnormal
            3:  return 64'h8000_0000_0000_0001;
            4:  return 64'h000F_FFFF_FFFF_FFFF; // max subnormal
            5:  return 64'h0010_0000_0000_0000; // min normal
            6:  return 64'h3FF0_0000_0000_0000; // 1.0
            7:  return 64'h3FF0_0000_0000_0001; // 1.0 + ulp
            8:  return 64'hBFF0_0000_0000_0000; // -1.0
            9:  return 64'hBFF0_0000_0000_0001; // -(1.0 + ulp)
            10: return 64'h7FEF_FFFF_FFFF_FFFF; // max finite
            11: return 64'hFFEF_FFFF_FFFF_FFFF;
            12: return 64'h7FF0_0000_0000_0000; // +inf
            13: return 64'hFFF0_0000_0000_0000; // -inf
            14: return 64'h7FF8_0000_0000_0000; // quiet NaN
            15: return 64'h7FF0_0000_0000_0001; // signalling NaN
            16: return 64'hFFFF_FFFF_FFFF_FFFF; // negative quiet NaN
            default: return 64'h4000_0000_0000_0000; // 2.0
        endcase
    endfunction

    function automatic bit is_nan(input logic [63:0] w);
        return (w[62:52] == 11'h7FF) && (w[51:0] != 0);
    endfunction

    task automatic check(input string req, input logic [3:0] exp_cc,
                         input logic exp_inv);
        n_checks++;
        if (nzcv !== exp_cc || invalid !== exp_inv) begin
            n_fail++;
            $display("FAIL %s: d=%h m=%h z=%0b q=%0b got nzcv=%b inv=%b exp nzcv=%b inv=%b",
                     req, opd_d, opd_m, cmp_zero, sig_qnan, nzcv, invalid,
                     exp_cc, exp_inv);
        end
    endtask

    // Drive one compare and check it one edge later.
    task automatic run_one(input logic [63:0] d, input logic [63:0] m,
                           input logic z, input logic q);
        logic [63:0] me;
        logic [3:0]  ecc;
        logic        einv;
        string       req;
        real         rd;
        real         rm;
        @(negedge clk);
        in_valid = 1'b1; opd_d = d; opd_m = m; cmp_zero = z; sig_qnan = q;
        me   = z ? 64'h0 : m;
        einv = (is_nan(d) && (!d[51] || q)) || (is_nan(me) && (!me[51] || q));
        rd   = $bitstoreal(d);
        rm   = $bitstoreal(me);
        if (is_nan(d) || is_nan(me)) begin
            ecc = 4'b0011;
            req = einv ? (q ? "R6/R8" : "R6/R7") : "R6/R8";
        end else if (rd < rm) begin
            ecc = 4'b1000; req = z ? "R4/R9" : "R4";
        end else if (rd > rm) begin
            ecc = 4'b0010; req = z ? "R5/R9" : "R5";
        end else begin
            ecc = 4'b0110; req = z ? "R3/R9" : "R3";
        end
        @(negedge clk);
        check(req, ecc, einv); // R10: one edge of latency
    endtask

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b1;
        opd_d = 64'h7FF0_0000_0000_0001;
        repeat (2) @(negedge clk);
        check("R1", 4'b0000, 1'b0);
        rst_n = 1'b1;
        for (int z = 0; z < 2; z++)
            for (int q = 0; q < 2; q++)
                for (int i = 0; i < NV; i++)
                    for (int j = 0; j < NV; j++)
                        run_one(pick(i), pick(j), z[0], q[0]);
        // R2: idle cycle with NaN operands still reports nothing.
        @(negedge clk);
        in_valid = 1'b0; opd_d = 64'h7FF0_0000_0000_0001; sig_qnan = 1'b1;
        @(negedge clk);
        check("R2", 4'b0000, 1'b0);
        // R10: held outputs stay between edges.
        run_one(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0, 1'b0);
        #3;
        check("R10", 4'b1000, 1'b0);
        // R1: reset clears flags after a result.
        run_one(64'h7FF0_0000_0000_0001, 64'h0, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 4'b0000, 1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang exp completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule